// File: doc/BRIEF.md
# Packed Lane Add/Subtract and Compare Unit

This execution unit works on two 64-bit words that each hold several small integers side by side. A lane-width select splits both words into eight 8-bit, four 16-bit or two 32-bit lanes. One operation code is then applied to every lane at once, with no carry or borrow crossing a lane boundary. Addition and subtraction come in three forms: plain modular, clamped to the signed range, and clamped to the unsigned range. Two compares produce per-lane masks. Four bitwise operations act on the whole word.

The result is captured in a register, so a request presented with `in_valid` high appears one clock later with `out_valid` high. No flags of any kind are produced. A caller that needs a branch-free select can combine a compare mask with the bitwise operations.

Top module: `packed_sat_alu`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Lane i occupies bits [i*w +: w]. A carry or borrow never passes from one lane into the next.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `result` loads only when `in_valid` is high and otherwise keeps its value.
- R3: Op 0 (add) and op 3 (subtract, first operand minus second) produce the lane result modulo 2^w and drop the carry-out.
- R4: Op 2 (unsigned clamped add) gives all ones when the true sum exceeds 2^w−1. Op 5 (unsigned clamped subtract) gives zero when the true difference is negative. Otherwise both give the exact value.
- R5: Op 1 (signed clamped add) and op 4 (signed clamped subtract) treat lanes as two's complement. A result above the range gives 0x7F…F, a result below it gives 0x80…0, and an in-range result is exact. Examples for 8 bits: 0x7F+0x01=0x7F and 0x80−0x01=0x80.
- R6: On 32-bit lanes, ops 1, 2, 4 and 5 do not clamp and behave like ops 0 and 3.
- R7: Op 6 writes all ones to a lane when the two lanes are equal and all zeros otherwise. Op 7 does the same when the first operand is greater than the second, taken as signed.
- R8: Ops 8 (A&B), 9 ((~A)&B), 10 (A|B) and 11 (A^B) act on all 64 bits and ignore `lane_sel`.
- R9: Op codes 12 to 15 produce a result of zero.
- R10: After reset, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_a | input | 64 | First operand (A) |
| src_b | input | 64 | Second operand (B) |
| lane_sel | input | 2 | Lane width select |
| op_code | input | 4 | Operation code |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered packed result |

## Verification
The bench goes after the lane-boundary corner cases, where an error is easy to spot:
- A carry that leaks between lanes would turn 0x00FF+0x0001 in a 16-bit lane into a wrong upper byte, or would disturb the neighbouring lane in 8-bit mode.
- A signed clamp keyed on the unsigned carry would wrap 0x7F+0x01 to 0x80 or clamp the wrong way on 0x80−0x01.
- An unsigned subtract that wraps would turn 0x00−0x01 into 0xFF.
- Clamping left enabled on 32-bit lanes, an unsigned greater-than, or a swapped AND-NOT operand order each shows up as a mismatch in the sweep over the operand grid.

// File: rtl/psat_pkg.sv
package psat_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDS = 4'd1,
      OP_ADDU = 4'd2,
      OP_SUB  = 4'd3,
      OP_SUBS = 4'd4,
      OP_SUBU = 4'd5,
      OP_CEQ  = 4'd6,
      OP_CGT  = 4'd7,
      OP_AND  = 4'd8,
      OP_ANDN = 4'd9,
      OP_OR   = 4'd10,
      OP_XOR  = 4'd11
   } op_e;

   localparam int unsigned NUM_WIDTHS = 3;
   localparam int unsigned MIN_LANE_W = 8;

   function automatic logic is_lane_op(input logic [3:0] code);
      return code <= 4'd7;
   endfunction

   function automatic logic is_bit_op(input logic [3:0] code);
      return (code >= 4'd8) && (code <= 4'd11);
   endfunction

endpackage

// File: rtl/psat_lane.sv
module psat_lane
   import psat_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  op_e          op,
   output logic [W-1:0] y
);

   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] UMAX = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         $error("psat_lane: lane width must be at least 2");
      end
   endgenerate

   logic [W:0] sum_x;
   logic [W:0] dif_x;
   logic       sov_add;
   logic       sov_sub;
   logic       eq;
   logic       sgt;

   always_comb begin
      sum_x   = {1'b0, a} + {1'b0, b};
      dif_x   = {1'b0, a} - {1'b0, b};
      sov_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
      sov_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
      eq      = (a == b);
      sgt     = ($signed(a) > $signed(b));
   end

   always_comb begin
      unique case (op)
         OP_ADD:  y = sum_x[W-1:0];
         OP_SUB:  y = dif_x[W-1:0];
         OP_ADDS: y = (SAT_EN && sov_add) ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
         OP_SUBS: y = (SAT_EN && sov_sub) ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
         OP_ADDU: y = (SAT_EN && sum_x[W]) ? UMAX : sum_x[W-1:0];
         OP_SUBU: y = (SAT_EN && dif_x[W]) ? '0 : dif_x[W-1:0];
         OP_CEQ:  y = {W{eq}};
         OP_CGT:  y = {W{sgt}};
         default: y = '0;
      endcase
   end

   // R4: an unsigned clamped sum never falls below the first operand
   always_comb begin
      if (SAT_EN && op == OP_ADDU) begin
         a_r4_uadd_floor: assert (y >= a);
      end
   end

   // R4: an unsigned clamped difference never exceeds the first operand
   always_comb begin
      if (SAT_EN && op == OP_SUBU) begin
         a_r4_usub_ceiling: assert (y <= a);
      end
   end

   // R5: two non-negative lanes never add to a negative clamped result
   always_comb begin
      if (SAT_EN && op == OP_ADDS && !a[W-1] && !b[W-1]) begin
         a_r5_sadd_pos: assert (!y[W-1]);
      end
   end

   // R5: two negative lanes never add to a non-negative clamped result
   always_comb begin
      if (SAT_EN && op == OP_ADDS && a[W-1] && b[W-1]) begin
         a_r5_sadd_neg: assert (y[W-1]);
      end
   end

endmodule

// File: rtl/psat_bank.sv
module psat_bank
   import psat_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned LANE_W = 8,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  op_e               op,
   output logic [DATA_W-1:0] y
);

   localparam int unsigned LANES = DATA_W / LANE_W;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_split
         $error("psat_bank: data width must be a multiple of the lane width");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         psat_lane #(
            .W      (LANE_W),
            .SAT_EN (SAT_EN)
         ) i_lane (
            .a  (a[i*LANE_W +: LANE_W]),
            .b  (b[i*LANE_W +: LANE_W]),
            .op (op),
            .y  (y[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/psat_bitwise.sv
module psat_bitwise
   import psat_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  op_e               op,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_ANDN: y = ~a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/packed_sat_alu.sv
module packed_sat_alu
   import psat_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter bit          SAT_WIDE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [1:0]        lane_sel,
   input  logic [3:0]        op_code,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   localparam int unsigned MAX_LANE_W = MIN_LANE_W << (NUM_WIDTHS - 1);
   localparam int unsigned BYTES      = DATA_W / MIN_LANE_W;

   generate
      if (DATA_W % MAX_LANE_W != 0) begin : g_bad_width
         $error("packed_sat_alu: data width must be a multiple of the widest lane");
      end
   endgenerate

   op_e               op;
   logic [DATA_W-1:0] bank_y [NUM_WIDTHS];
   logic [DATA_W-1:0] bit_y;
   logic [DATA_W-1:0] lane_y;
   logic [DATA_W-1:0] next_y;

   assign op = op_e'(op_code);

   generate
      for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
         localparam int unsigned LW  = MIN_LANE_W << g;
         localparam bit          SAT = (g < NUM_WIDTHS - 1) || SAT_WIDE;
         psat_bank #(
            .DATA_W (DATA_W),
            .LANE_W (LW),
            .SAT_EN (SAT)
         ) i_bank (
            .a  (src_a),
            .b  (src_b),
            .op (op),
            .y  (bank_y[g])
         );
      end
   endgenerate

   psat_bitwise #(
      .DATA_W (DATA_W)
   ) i_bitwise (
      .a  (src_a),
      .b  (src_b),
      .op (op),
      .y  (bit_y)
   );

   always_comb begin
      unique case (lane_sel)
         2'd0:    lane_y = bank_y[0];
         2'd1:    lane_y = bank_y[1];
         default: lane_y = bank_y[2];
      endcase
   end

   always_comb begin
      if (is_lane_op(op_code)) begin
         next_y = lane_y;
      end else if (is_bit_op(op_code)) begin
         next_y = bit_y;
      end else begin
         next_y = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= next_y;
         end
      end
   end

   // R2: a request is answered on the next cycle
   a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2: no answer without a request
   a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2: the result holds while idle
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   // R9: reserved codes give zero
   a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code >= 4'd12) |=> (result == '0));

   // R7: compare on byte lanes yields a full mask per byte
   generate
      for (genvar k = 0; k < BYTES; k++) begin : g_mask_chk
         a_r7_byte_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_sel == 2'd0 && (op_code == 4'd6 || op_code == 4'd7))
            |=> (result[k*MIN_LANE_W +: MIN_LANE_W] == '0 ||
                 result[k*MIN_LANE_W +: MIN_LANE_W] == '1));
      end
   endgenerate

endmodule

// File: tb/test_packed_sat_alu.sv
module test_packed_sat_alu;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [1:0]  lane_sel = '0;
   logic [3:0]  op_code = '0;
   logic        out_valid;
   logic [63:0] result;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   packed_sat_alu i_packed_sat_alu (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .src_a     (src_a),
      .src_b     (src_b),
      .lane_sel  (lane_sel),
      .op_code   (op_code),
      .out_valid (out_valid),
      .result    (result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input int sel, input int op);
      int          w;
      int          n;
      longint      m;
      longint      half;
      longint      ua;
      longint      ub;
      longint      sa;
      longint      sb;
      longint      v;
      logic [63:0] lv;
      logic [63:0] r;
      bit          sat;
      w   = (sel == 0) ? 8 : (sel == 1) ? 16 : 32;
      n   = 64 / w;
      m   = (longint'(1) << w) - 1;
      half = longint'(1) << (w - 1);
      sat = (w < 32);
      r   = '0;
      if (op == 8)  return a & b;
      if (op == 9)  return ~a & b;
      if (op == 10) return a | b;
      if (op == 11) return a ^ b;
      if (op >= 12) return '0;
      for (int k = 0; k < n; k++) begin
         ua = longint'((a >> (k*w)) & 64'(m));
         ub = longint'((b >> (k*w)) & 64'(m));
         sa = (ua >= half) ? ua - (longint'(1) << w) : ua;
         sb = (ub >= half) ? ub - (longint'(1) << w) : ub;
         case (op)
            0: v = ua + ub;
            3: v = ua - ub;
            1: begin
               v = sa + sb;
               if (sat && v > half - 1) v = half - 1;
               if (sat && v < -half)    v = -half;
            end
            4: begin
               v = sa - sb;
               if (sat && v > half - 1) v = half - 1;
               if (sat && v < -half)    v = -half;
            end
            2: begin
               v = ua + ub;
               if (sat && v > m) v = m;
            end
            5: begin
               v = ua - ub;
               if (sat && v < 0) v = 0;
            end
            6: v = (ua == ub) ? m : 0;
            default: v = (sa > sb) ? m : 0;
         endcase
         lv = 64'(v) & 64'(m);
         r  = r | (lv << (k*w));
      end
      return r;
   endfunction

   function automatic string tag_of(input int sel, input int op);
      if (op == 0 || op == 3) return "R3";
      if (op == 1 || op == 4) return (sel >= 2) ? "R6" : "R5";
      if (op == 2 || op == 5) return (sel >= 2) ? "R6" : "R4";
      if (op == 6 || op == 7) return "R7";
      if (op <= 11)           return "R8";
      return "R9";
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %016h expected %016h", tag, got, exp);
      end
   endtask

   // one request per cycle: drive now, compare at the next falling edge
   task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input int sel, input int op, input logic [63:0] exp);
      src_a    = a;
      src_b    = b;
      lane_sel = 2'(sel);
      op_code  = 4'(op);
      in_valid = 1'b1;
      @(negedge clk);
      check(tag, {63'd0, out_valid}, 64'd1);
      check(tag, result, exp);
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  bvals [8];
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] held;
      bvals[0] = 8'h00; bvals[1] = 8'h01; bvals[2] = 8'h7F; bvals[3] = 8'h80;
      bvals[4] = 8'hFF; bvals[5] = 8'h40; bvals[6] = 8'hC0; bvals[7] = 8'h3A;

      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", {63'd0, out_valid}, 64'd0);
      check("R10", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: signed clamps on byte lanes
      run_op("R5", {8{8'h7F}}, {8{8'h01}}, 0, 1, {8{8'h7F}});
      run_op("R5", {8{8'h80}}, {8{8'h01}}, 0, 4, {8{8'h80}});
      run_op("R5", {4{16'h8000}}, {4{16'h0001}}, 1, 4, {4{16'h8000}});
      // R4: unsigned clamps
      run_op("R4", {8{8'h00}}, {8{8'h01}}, 0, 5, {8{8'h00}});
      run_op("R4", {4{16'hFFF0}}, {4{16'h0020}}, 1, 2, {4{16'hFFFF}});
      // R1: carry stays inside its lane
      run_op("R1", {8{8'hFF}}, {8{8'h01}}, 0, 0, 64'd0);
      run_op("R1", {4{16'h00FF}}, {4{16'h0001}}, 1, 0, {4{16'h0100}});
      run_op("R1", {2{32'h0000_0000}}, {2{32'h0000_0001}}, 3, 3, {2{32'hFFFF_FFFF}});
      // R6: no clamp on 32-bit lanes
      run_op("R6", {2{32'h7FFF_FFFF}}, {2{32'h1}}, 2, 1, {2{32'h8000_0000}});
      run_op("R6", {2{32'h0}}, {2{32'h1}}, 2, 5, {2{32'hFFFF_FFFF}});
      // R7: signed greater-than, not unsigned
      run_op("R7", {8{8'h01}}, {8{8'hFF}}, 0, 7, {8{8'hFF}});
      // R8: AND-NOT complements the first operand
      run_op("R8", 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_FFFF_FFFF, 1, 9,
             64'h0F0F_0000_FFFF_0000);

      // R2: idle cycle, output strobe drops and result holds
      held     = result;
      in_valid = 1'b0;
      src_a    = 64'h1234_5678_9ABC_DEF0;
      op_code  = 4'd11;
      @(negedge clk);
      check("R2", {63'd0, out_valid}, 64'd0);
      check("R2", result, held);

      // sweep: operand grid x every op x every lane select
      for (int i = 0; i < 256; i += 3) begin
         for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 8; k++) begin
               a[k*8 +: 8] = 8'((i + k*37) & 255);
               b[k*8 +: 8] = (k % 2 == 0) ? bvals[j] : 8'((bvals[j] + k) & 255);
            end
            for (int sel = 0; sel < 4; sel++) begin
               for (int op = 0; op < 16; op++) begin
                  src_a    = a;
                  src_b    = b;
                  lane_sel = 2'(sel);
                  op_code  = 4'(op);
                  in_valid = 1'b1;
                  @(negedge clk);
                  check(tag_of(sel, op), result, model(a, b, sel, op));
               end
            end
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule